// File: doc/BRIEF.md
# I2C Power-Up Command Sequencer

This block configures a board's I2C peripherals straight after power-up, before any host link is running. It reads a small on-chip command ROM one word at a time, in ascending address order. Each 16-bit word becomes an access on the register port of a byte-level I2C controller. The block starts by itself when reset is released. A typical script selects a branch of the bus multiplexer, programs a clock switch so that a 125 MHz reference reaches the transceivers, and reads the six EEPROM bytes that hold the board's EUI-48 MAC address.

Each command word holds four fields. A 3-bit bus number goes to the multiplexer select output. A direction flag chooses between a register write and a register read. A 4-bit selector picks the controller register. An 8-bit data byte is used on writes. A write to the controller's command register starts an I2C transfer. After such a write, the sequencer polls the status register until the transfer has finished. It records a missing acknowledge in a sticky error flag and carries on with the script.

Bytes returned by read commands are collected into a 48-bit MAC register. The script ends on an all-ones word, or after the last ROM word if no marker is present. At that point the block raises a done flag, which an external multiplexer uses to hand the controller over to the host path. After done, the block issues no further bus cycles.

Top module: `i2c_boot_seq`

## Requirements
- R1: A command word decodes as follows. Bits 15..13 are driven on `bus_sel`, and every bus cycle of that command runs with this value. Bit 12 set means a register read and bit 12 clear means a register write. Bits 11..8 appear on `wb_adr`. Bits 7..0 appear on `wb_dat_o` for a write.
- R2: While reset is held, `rom_addr`, `bus_sel` and `mac_addr` are zero and `wb_cyc`, `seq_done`, `nack_err` and `mac_valid` are low. After reset is released, the bus cycle for ROM word 0 starts without any other input.
- R3: Commands execute one at a time in address order. `rom_addr` only ever steps by +1, and each non-marker word produces exactly one command access.
- R4: A write to selector 4 (the command register) is followed by reads of selector 4 (the status register), repeated until status bit 1 (transfer in progress) reads 0. The next ROM word is not fetched before that read.
- R5: Each read command shifts its returned byte into `mac_addr` from the low end, so the first byte read ends up as the most significant byte. `mac_valid` rises after the sixth byte. Once `mac_valid` is set, later reads leave `mac_addr` unchanged.
- R6: If status bit 7 (acknowledge missing) is set in the status read that ends a poll, `nack_err` is set and stays set. The script then continues with the next word.
- R7: Word 16'hFFFF ends the script without a bus cycle and raises `seq_done`. If no marker is present, `seq_done` rises after the word at the last ROM address has executed.
- R8: Once `seq_done` is high it stays high, `rom_addr` holds its value and `wb_cyc` stays low.
- R9: While a bus cycle waits for `wb_ack`, `wb_cyc`/`wb_stb` stay high and `wb_adr`, `wb_we` and `wb_dat_o` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| rom_addr | output | 6 | Command ROM word address |
| rom_data | input | 16 | Command word at `rom_addr` (asynchronous read) |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | 4 | Controller register selector |
| wb_dat_o | output | 8 | Write data to controller |
| wb_dat_i | input | 8 | Read data from controller |
| wb_ack | input | 1 | Bus acknowledge |
| bus_sel | output | 3 | I2C bus multiplexer select |
| mac_addr | output | 48 | Collected MAC address |
| mac_valid | output | 1 | Six MAC bytes collected |
| nack_err | output | 1 | Sticky missing-acknowledge flag |
| seq_done | output | 1 | Script finished; controller belongs to host |

## Verification
Several properties are checked on every cycle. The assertions cover the single-step ROM address walk, bus signals held stable while a cycle waits for its acknowledge, the frozen MAC after six bytes, the sticky error flag, and a silent bus with a fixed address once done. Other behaviour only shows up in the bench's scenarios, which compare a log of every bus access against expected values: the field decoding and its mapping onto the bus, the exact number of status polls for a given busy time, byte order in the MAC, continuation after a missing acknowledge, and termination both on the marker and at the end of the ROM.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef struct packed {
        logic [2:0] bus;
        logic       rd;
        logic [3:0] sel;
        logic [7:0] data;
    } boot_cmd_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_ACCESS,
        ST_POLL_ISSUE,
        ST_POLL_WAIT,
        ST_ADVANCE,
        ST_DONE
    } seq_state_t;

    localparam logic [15:0] END_MARK = 16'hFFFF;

    function automatic boot_cmd_t decode_cmd(input logic [15:0] word);
        return boot_cmd_t'(word);
    endfunction

    function automatic logic is_end(input logic [15:0] word);
        return word == END_MARK;
    endfunction

endpackage

// File: rtl/i2cb_wb_engine.sv
module i2cb_wb_engine (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       req_we,
    input  logic [3:0] req_adr,
    input  logic [7:0] req_dat,
    output logic       done,
    output logic [7:0] rdata,
    output logic       wb_cyc,
    output logic       wb_stb,
    output logic       wb_we,
    output logic [3:0] wb_adr,
    output logic [7:0] wb_dat_o,
    input  logic [7:0] wb_dat_i,
    input  logic       wb_ack
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_cyc   <= 1'b0;
            wb_we    <= 1'b0;
            wb_adr   <= '0;
            wb_dat_o <= '0;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            if (wb_cyc) begin
                if (wb_ack) begin
                    wb_cyc <= 1'b0;
                    done   <= 1'b1;
                    rdata  <= wb_dat_i;
                end
            end else if (start) begin
                wb_cyc   <= 1'b1;
                wb_we    <= req_we;
                wb_adr   <= req_adr;
                wb_dat_o <= req_dat;
            end
        end
    end

    assign wb_stb = wb_cyc;

    // R9: request held until acknowledged
    p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && !wb_ack) |=> (wb_cyc && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_o)));

    // R3: one access at a time, a new request never overlaps an open cycle
    p_start_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        start |-> !wb_cyc);

endmodule

// File: rtl/i2cb_mac_shift.sv
module i2cb_mac_shift #(
    parameter int unsigned MAC_BYTES = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shift_en,
    input  logic [7:0]             byte_in,
    output logic [8*MAC_BYTES-1:0] mac,
    output logic                   valid
);
    localparam int unsigned MAC_W = 8 * MAC_BYTES;
    localparam int unsigned CW    = $clog2(MAC_BYTES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mac   <= '0;
            cnt   <= '0;
            valid <= 1'b0;
        end else if (shift_en && !valid) begin
            mac <= {mac[MAC_W-9:0], byte_in};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(MAC_BYTES - 1))
                valid <= 1'b1;
        end
    end

    // R5: address frozen once complete
    p_mac_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        valid |=> (valid && $stable(mac)));

endmodule

// File: rtl/i2c_boot_seq.sv
module i2c_boot_seq
    import i2cb_pkg::*;
#(
    parameter int unsigned ROM_DEPTH = 64,
    parameter int unsigned CMD_SEL   = 4,
    parameter int unsigned STAT_SEL  = 4,
    parameter int unsigned TIP_BIT   = 1,
    parameter int unsigned NACK_BIT  = 7,
    parameter int unsigned MAC_BYTES = 6
) (
    input  logic        clk,
    input  logic        rst,
    output logic [5:0]  rom_addr,
    input  logic [15:0] rom_data,
    output logic        wb_cyc,
    output logic        wb_stb,
    output logic        wb_we,
    output logic [3:0]  wb_adr,
    output logic [7:0]  wb_dat_o,
    input  logic [7:0]  wb_dat_i,
    input  logic        wb_ack,
    output logic [2:0]  bus_sel,
    output logic [47:0] mac_addr,
    output logic        mac_valid,
    output logic        nack_err,
    output logic        seq_done
);
    localparam int unsigned AW = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;
    localparam logic [AW-1:0] LAST_ADDR = AW'(ROM_DEPTH - 1);

    seq_state_t    state;
    boot_cmd_t     cur;
    logic [AW-1:0] addr_q;
    logic          cmd_rd_q;
    logic [3:0]    cmd_sel_q;

    logic          eng_start, eng_we, eng_done;
    logic [3:0]    eng_adr;
    logic [7:0]    eng_rdata;
    logic          cap_en;

    assign cur = decode_cmd(rom_data);

    always_comb begin
        eng_start = 1'b0;
        eng_we    = 1'b0;
        eng_adr   = 4'(STAT_SEL);
        if (state == ST_FETCH && !is_end(rom_data)) begin
            eng_start = 1'b1;
            eng_we    = !cur.rd;
            eng_adr   = cur.sel;
        end else if (state == ST_POLL_ISSUE) begin
            eng_start = 1'b1;
        end
    end

    assign cap_en = (state == ST_ACCESS) && eng_done && cmd_rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_FETCH;
            addr_q    <= '0;
            cmd_rd_q  <= 1'b0;
            cmd_sel_q <= '0;
            bus_sel   <= '0;
            nack_err  <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    if (is_end(rom_data)) begin
                        state <= ST_DONE;
                    end else begin
                        cmd_rd_q  <= cur.rd;
                        cmd_sel_q <= cur.sel;
                        bus_sel   <= cur.bus;
                        state     <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (eng_done)
                        state <= (!cmd_rd_q && cmd_sel_q == 4'(CMD_SEL)) ? ST_POLL_ISSUE : ST_ADVANCE;
                end
                ST_POLL_ISSUE: state <= ST_POLL_WAIT;
                ST_POLL_WAIT: begin
                    if (eng_done) begin
                        if (eng_rdata[TIP_BIT]) begin
                            state <= ST_POLL_ISSUE;
                        end else begin
                            if (eng_rdata[NACK_BIT])
                                nack_err <= 1'b1;
                            state <= ST_ADVANCE;
                        end
                    end
                end
                ST_ADVANCE: begin
                    if (addr_q == LAST_ADDR) begin
                        state <= ST_DONE;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                        state  <= ST_FETCH;
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    assign rom_addr = 6'(addr_q);
    assign seq_done = (state == ST_DONE);

    i2cb_wb_engine i_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .req_we   (eng_we),
        .req_adr  (eng_adr),
        .req_dat  (cur.data),
        .done     (eng_done),
        .rdata    (eng_rdata),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_adr   (wb_adr),
        .wb_dat_o (wb_dat_o),
        .wb_dat_i (wb_dat_i),
        .wb_ack   (wb_ack)
    );

    i2cb_mac_shift #(.MAC_BYTES(MAC_BYTES)) i_mac (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cap_en),
        .byte_in  (eng_rdata),
        .mac      (mac_addr),
        .valid    (mac_valid)
    );

    // R3: address walks upward by exactly one
    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(rom_addr) |-> (rom_addr == 6'($past(rom_addr) + 1'b1)));

    // R8: done is final, bus silent, address held
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> (seq_done && $stable(rom_addr)));
    p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> !wb_cyc);

    // R6: missing-acknowledge flag is sticky
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        nack_err |=> nack_err);

endmodule

// File: tb/test_i2c_boot_seq.sv
`timescale 1ns/1ps
module test_i2c_boot_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  rom_addr;
    logic [15:0] rom_data;
    logic        wb_cyc, wb_stb, wb_we;
    logic [3:0]  wb_adr;
    logic [7:0]  wb_dat_o, wb_dat_i;
    logic        wb_ack;
    logic [2:0]  bus_sel;
    logic [47:0] mac_addr;
    logic        mac_valid, nack_err, seq_done;

    always #2.5 clk = ~clk;

    // stimulus-side memories and configuration (written by the main thread only)
    logic [15:0] rom [0:63];
    logic [7:0]  ee  [0:7];
    int          ack_lat   = 0;
    int          poll_busy = 0;
    logic        nack_cfg  = 1'b0;

    // controller model state
    int          wcnt, polls_left, ee_ptr, log_n;
    logic [15:0] log_q [0:255];
    int          hold_viol;
    logic        prev_pend;
    logic [3:0]  prev_adr;
    logic        prev_we;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_q [0:127];
    int          exp_n;

    assign rom_data = rom[rom_addr];

    always_comb begin
        if (wb_adr == 4'd4)
            wb_dat_i = {nack_cfg, 5'b0, (polls_left > 0), 1'b0};
        else if (wb_adr == 4'd3)
            wb_dat_i = ee[ee_ptr[2:0]];
        else
            wb_dat_i = 8'h00;
    end

    always @(posedge clk) begin
        if (rst) begin
            wb_ack     <= 1'b0;
            wcnt       <= 0;
            polls_left <= 0;
            ee_ptr     <= 0;
            log_n      <= 0;
        end else if (wb_ack) begin
            wb_ack <= 1'b0;
            if (wb_stb) begin
                log_q[log_n[7:0]] <= {bus_sel, wb_we, wb_adr, wb_we ? wb_dat_o : wb_dat_i};
                log_n <= log_n + 1;
                if (wb_we && wb_adr == 4'd4) polls_left <= poll_busy;
                if (!wb_we && wb_adr == 4'd4 && polls_left > 0) polls_left <= polls_left - 1;
                if (!wb_we && wb_adr == 4'd3) ee_ptr <= ee_ptr + 1;
            end
        end else if (wb_stb) begin
            if (wcnt == ack_lat) begin
                wb_ack <= 1'b1;
                wcnt   <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // bus hold monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst) begin
            hold_viol <= 0;
            prev_pend <= 1'b0;
        end else begin
            if (prev_pend && (!wb_stb || !wb_cyc || wb_adr != prev_adr || wb_we != prev_we))
                hold_viol <= hold_viol + 1;
            prev_pend <= wb_stb && !wb_ack;
            prev_adr  <= wb_adr;
            prev_we   <= wb_we;
        end
    end

    i2c_boot_seq i_i2c_boot_seq (
        .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack),
        .bus_sel(bus_sel), .mac_addr(mac_addr), .mac_valid(mac_valid),
        .nack_err(nack_err), .seq_done(seq_done)
    );

    function automatic logic [15:0] ent(input logic [2:0] b, input logic w,
                                        input logic [3:0] a, input logic [7:0] d);
        return {b, w, a, d};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 64; i++) rom[i] = 16'hFFFF;
        exp_n = 0;
    endtask

    task automatic push_exp(input logic [15:0] e);
        exp_q[exp_n] = e;
        exp_n++;
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int k = 0;
        while (!seq_done && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk(seq_done, {tag, " seq_done reached"}, 64'(seq_done), 64'd1);
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_log(input string tag);
        chk(log_n == exp_n, {tag, " access count"}, 64'(log_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < log_n; i++)
            chk(log_q[i] == exp_q[i], $sformatf("%s access %0d", tag, i), 64'(log_q[i]), 64'(exp_q[i]));
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rom_addr == 0 && bus_sel == 0 && mac_addr == 0, "R2 reset addr/bus/mac", 64'(rom_addr), 64'd0);
        chk(!wb_cyc && !seq_done && !nack_err && !mac_valid, "R2 reset flags",
            64'({wb_cyc, seq_done, nack_err, mac_valid}), 64'd0);
    endtask

    task automatic t_write_script();
        clear_rom();
        ack_lat = 0; poll_busy = 3; nack_cfg = 1'b0;
        rom[0] = {3'd5, 1'b0, 4'd3, 8'hE0};
        rom[1] = {3'd5, 1'b0, 4'd4, 8'h90};
        rom[2] = {3'd2, 1'b0, 4'd0, 8'h2A};
        push_exp(ent(3'd5, 1'b1, 4'd3, 8'hE0));
        push_exp(ent(3'd5, 1'b1, 4'd4, 8'h90));
        for (int i = 0; i < 3; i++) push_exp(ent(3'd5, 1'b0, 4'd4, 8'h02));
        push_exp(ent(3'd5, 1'b0, 4'd4, 8'h00));
        push_exp(ent(3'd2, 1'b1, 4'd0, 8'h2A));
        apply_reset();
        wait_done("R1 R2 R4 R7 write script");
        cmp_log("R1 R4 write script");
        chk(rom_addr == 6'd3, "R3 R7 stops on marker", 64'(rom_addr), 64'd3);
        chk(!nack_err, "R6 no error when acked", 64'(nack_err), 64'd0);
        chk(bus_sel == 3'd2, "R1 bus_sel of last command", 64'(bus_sel), 64'd2);
    endtask

    task automatic t_mac(input int nreads, input int lat, input logic [47:0] exp_mac,
                         input logic exp_valid, input string tag);
        clear_rom();
        ack_lat = lat; poll_busy = 0; nack_cfg = 1'b0;
        for (int i = 0; i < nreads; i++) begin
            rom[i] = {3'd3, 1'b1, 4'd3, 8'h00};
            push_exp(ent(3'd3, 1'b0, 4'd3, ee[i]));
        end
        apply_reset();
        wait_done(tag);
        cmp_log(tag);
        chk(mac_addr == exp_mac, {tag, " mac value"}, 64'(mac_addr), 64'(exp_mac));
        chk(mac_valid == exp_valid, {tag, " mac_valid"}, 64'(mac_valid), 64'(exp_valid));
        chk(hold_viol == 0, "R9 request held until ack", 64'(hold_viol), 64'd0);
    endtask

    task automatic t_nack();
        clear_rom();
        ack_lat = 1; poll_busy = 1; nack_cfg = 1'b1;
        rom[0] = {3'd1, 1'b0, 4'd4, 8'h10};
        rom[1] = {3'd1, 1'b0, 4'd0, 8'h55};
        push_exp(ent(3'd1, 1'b1, 4'd4, 8'h10));
        push_exp(ent(3'd1, 1'b0, 4'd4, 8'h82));
        push_exp(ent(3'd1, 1'b0, 4'd4, 8'h80));
        push_exp(ent(3'd1, 1'b1, 4'd0, 8'h55));
        apply_reset();
        wait_done("R6 nack");
        cmp_log("R6 nack continues");
        chk(nack_err, "R6 nack_err set", 64'(nack_err), 64'd1);
        nack_cfg = 1'b0;
    endtask

    task automatic t_full_rom();
        clear_rom();
        ack_lat = 0; poll_busy = 0; nack_cfg = 1'b0;
        for (int i = 0; i < 64; i++) begin
            rom[i] = {3'(i % 8), 1'b0, 4'd0, 8'(i)};
            push_exp(ent(3'(i % 8), 1'b1, 4'd0, 8'(i)));
        end
        apply_reset();
        wait_done("R7 no marker");
        cmp_log("R3 R7 full rom");
        chk(rom_addr == 6'd63, "R7 ends at last address", 64'(rom_addr), 64'd63);
    endtask

    task automatic t_quiet_after_done();
        int n0 = log_n;
        logic [5:0] a0 = rom_addr;
        int cyc_seen = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (wb_cyc) cyc_seen++;
        end
        chk(cyc_seen == 0 && log_n == n0, "R8 no bus cycles after done", 64'(cyc_seen), 64'd0);
        chk(seq_done && rom_addr == a0, "R8 done and address held", 64'(rom_addr), 64'(a0));
    endtask

    logic wd_fired = 1'b0;

    initial begin
        ee[0] = 8'h00; ee[1] = 8'h1E; ee[2] = 8'hC0; ee[3] = 8'hFF;
        ee[4] = 8'hEE; ee[5] = 8'h42; ee[6] = 8'h99; ee[7] = 8'h77;
        clear_rom();
        fork
            begin
                t_reset_state();
                t_write_script();
                t_mac(5, 0, 48'h0000_1EC0_FFEE, 1'b0, "R5 five bytes");
                t_mac(7, 3, 48'h001E_C0FF_EE42, 1'b1, "R5 R9 seven bytes");
                t_nack();
                t_full_rom();
                t_quiet_after_done();
            end
            begin
                repeat (150000) @(posedge clk);
                wd_fired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule